// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block turns a list of I2C message descriptors into the sequence of byte-level commands that an I2C byte engine executes. Every descriptor carries a 7-bit target address, a read/write flag, a flag that continues the previous message's data phase without a new start, a flag marking the final message, and a byte count. The sequencer issues one command at a time. It waits for that command's completion and then picks the next step: start or repeated start, the address byte, data bytes, and the closing stop.

Bytes to be written are pulled one at a time from a valid/ready input stream, only when the data phase needs them. Received bytes leave on an output stream as single-cycle pulses. When a completion reports a bad acknowledge or an abort, the whole transfer ends at once with an I/O error. A cycle counter restarts on every accepted descriptor. If a message does not finish within a programmable number of cycles, the transfer ends with a timeout error. The end of every transfer is a single pulse: done or error. The cause stays readable until the next transfer begins.

Top module: `i2cseq_top`

## Requirements
- R1: After reset the block accepts descriptors (desc_ready=1), issues no command, raises neither xfer_done nor xfer_err, and shows err_code 0.
- R2: A message without the no-start flag begins with command code 1 (start) when it opens a transfer, and with code 2 (repeated start) otherwise. A no-start message issues neither of these and no address byte, and goes straight to its data phase.
- R3: After the start or repeated start completes, the block issues command code 3 (send byte) with cmd_byte equal to the 7-bit address in bits 7:1 and bit 0 set for a read.
- R4: Write bytes are taken from the write stream in arrival order, one code-3 command per byte. A zero-length write goes from the address phase directly to end-of-message handling.
- R5: Each byte read is requested with code 6 (receive and acknowledge), except the final byte of the message, which uses code 7 (receive without acknowledge). On each such completion, rd_valid pulses once with rd_data equal to cmd_rdata.
- R6: When a message's data is exhausted, code 10 (stop) is issued only if desc_last was set for it. Otherwise the next descriptor is accepted with no stop in between.
- R7: Completion of the stop, with status 0 or 1, produces a one-cycle xfer_done pulse. xfer_done and xfer_err never pulse together.
- R8: A completion whose status is 2 (acknowledge missing) or 3 (abort) ends the transfer at once: no further command, a one-cycle xfer_err pulse in the next cycle, err_code 1, and a return to accepting descriptors.
- R9: If a message is still unfinished timeout_limit+1 cycles after its descriptor was accepted, xfer_err pulses, err_code becomes 2 and the block returns to idle.
- R10: Only one command is outstanding at a time. cmd_valid is a one-cycle pulse that never coincides with desc_ready or wr_ready. The byte engine answers each command with a cmd_done pulse at least one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be accepted |
| desc_addr | input | 7 | Target address |
| desc_read | input | 1 | 1 = read message |
| desc_nostart | input | 1 | Continue data phase without start/address |
| desc_last | input | 1 | Final message of the transfer |
| desc_len | input | LEN_W | Byte count of the message |
| timeout_limit | input | TO_W | Per-message cycle budget |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte pulse |
| rd_data | output | 8 | Received byte |
| cmd_valid | output | 1 | Command issue pulse |
| cmd_code | output | 4 | Command code |
| cmd_byte | output | 8 | Byte to send with code 3 |
| cmd_done | input | 1 | Command completion pulse |
| cmd_status | input | 2 | 0 normal, 1 ack good, 2 ack missing, 3 abort |
| cmd_rdata | input | 8 | Byte received by a code 6/7 command |
| xfer_done | output | 1 | Transfer finished pulse |
| xfer_err | output | 1 | Transfer failed pulse |
| err_code | output | 2 | 0 none, 1 I/O error, 2 timeout |

## Verification
The stimulus targets the corner cases around message boundaries. A zero-length write that sent data or skipped the stop would leave the command log with the wrong length. A first message with the no-start flag set would reveal a start or address that leaked out. A one-byte read would show code 6 where code 7 belongs. Two messages in a row would show a stop between them, or a start instead of a repeated start. Errors are injected on the address byte and in the middle of a read, so a sequencer that kept going after a bad status would show extra commands or read bytes. With a silent engine the timeout is measured to the exact cycle, which exposes an off-by-one in the counter compare.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_START    = 4'd1,
        CMD_RESTART  = 4'd2,
        CMD_SEND     = 4'd3,
        CMD_GET_ACK  = 4'd6,
        CMD_GET_NACK = 4'd7,
        CMD_STOP     = 4'd10
    } bus_cmd_e;

    typedef enum logic [1:0] {
        XERR_NONE    = 2'd0,
        XERR_IO      = 2'd1,
        XERR_TIMEOUT = 2'd2
    } xfer_err_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_FETCH, SQ_START, SQ_ADDR,
        SQ_WFETCH, SQ_WRITE, SQ_READ, SQ_STOP
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
        logic              nostart;
        logic              last;
    } msg_hdr_t;

    function automatic logic [7:0] addr_byte(msg_hdr_t h);
        return {h.addr, h.rd};
    endfunction

    // status 2 and 3 both carry bit 1
    function automatic logic status_bad(logic [1:0] s);
        return s[1];
    endfunction

endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] tcnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            tcnt <= '0;
        else if (run && tcnt != limit)
            tcnt <= tcnt + TO_W'(1);
    end

    assign expired = run && !clear && (tcnt == limit);
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  msg_hdr_t         desc_hdr,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    output bus_cmd_e         cmd_code,
    output logic [7:0]       cmd_byte,
    input  logic             cmd_done,
    input  logic [1:0]       cmd_status,
    input  logic [7:0]       cmd_rdata,
    input  logic             tmo_expired,
    output logic             msg_accept,
    output logic             active,
    output logic             xfer_done,
    output logic             xfer_err,
    output xfer_err_e        err_code
);
    seq_state_e       st, st_n;
    msg_hdr_t         hdr_q, hdr_n;
    logic [LEN_W-1:0] len_q, len_n, cnt_q, cnt_n;
    logic             cv_q, cv_n, rv_q, rv_n, dn_q, dn_n, er_q, er_n;
    bus_cmd_e         cc_q, cc_n;
    logic [7:0]       cb_q, cb_n, rd_q, rd_n;
    xfer_err_e        ec_q, ec_n;
    logic             waiting, done_ok, done_bad, step_data;

    assign desc_ready = (st == SQ_IDLE) || (st == SQ_FETCH);
    assign wr_ready   = (st == SQ_WFETCH);
    assign msg_accept = desc_ready && desc_valid;
    assign active     = (st != SQ_IDLE);
    assign waiting    = (st == SQ_START) || (st == SQ_ADDR) || (st == SQ_WRITE) ||
                        (st == SQ_READ)  || (st == SQ_STOP);
    assign done_ok    = waiting && cmd_done && !status_bad(cmd_status);
    assign done_bad   = waiting && cmd_done &&  status_bad(cmd_status);

    always_comb begin
        st_n = st;  hdr_n = hdr_q; len_n = len_q; cnt_n = cnt_q;
        cv_n = 1'b0; cc_n = cc_q; cb_n = cb_q;
        rv_n = 1'b0; rd_n = rd_q; dn_n = 1'b0; er_n = 1'b0; ec_n = ec_q;
        step_data = 1'b0;
        case (st)
            SQ_IDLE, SQ_FETCH: if (desc_valid) begin
                hdr_n = desc_hdr;
                len_n = desc_len;
                cnt_n = '0;
                if (st == SQ_IDLE) ec_n = XERR_NONE;
                if (!desc_hdr.nostart) begin
                    cv_n = 1'b1;
                    cc_n = (st == SQ_IDLE) ? CMD_START : CMD_RESTART;
                    st_n = SQ_START;
                end else begin
                    step_data = 1'b1;
                end
            end
            SQ_START: if (done_ok) begin
                cv_n = 1'b1;
                cc_n = CMD_SEND;
                cb_n = addr_byte(hdr_q);
                st_n = SQ_ADDR;
            end
            SQ_ADDR, SQ_WRITE: if (done_ok) step_data = 1'b1;
            SQ_WFETCH: if (wr_valid) begin
                cv_n  = 1'b1;
                cc_n  = CMD_SEND;
                cb_n  = wr_data;
                cnt_n = cnt_q + LEN_W'(1);
                st_n  = SQ_WRITE;
            end
            SQ_READ: if (done_ok) begin
                rv_n  = 1'b1;
                rd_n  = cmd_rdata;
                cnt_n = cnt_q + LEN_W'(1);
                step_data = 1'b1;
            end
            SQ_STOP: if (done_ok) begin
                dn_n = 1'b1;
                st_n = SQ_IDLE;
            end
            default: st_n = SQ_IDLE;
        endcase

        // shared decision: next data byte, or end of message
        if (step_data) begin
            if (cnt_n < len_n) begin
                if (hdr_n.rd) begin
                    cv_n = 1'b1;
                    cc_n = (cnt_n == len_n - LEN_W'(1)) ? CMD_GET_NACK : CMD_GET_ACK;
                    st_n = SQ_READ;
                end else begin
                    st_n = SQ_WFETCH;
                end
            end else if (hdr_n.last) begin
                cv_n = 1'b1;
                cc_n = CMD_STOP;
                st_n = SQ_STOP;
            end else begin
                st_n = SQ_FETCH;
            end
        end

        if (done_bad || tmo_expired) begin
            cv_n = 1'b0;
            rv_n = 1'b0;
            dn_n = 1'b0;
            er_n = 1'b1;
            ec_n = done_bad ? XERR_IO : XERR_TIMEOUT;
            st_n = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE;  hdr_q <= '0; len_q <= '0; cnt_q <= '0;
            cv_q <= 1'b0; cc_q <= CMD_NONE; cb_q <= '0;
            rv_q <= 1'b0; rd_q <= '0; dn_q <= 1'b0; er_q <= 1'b0;
            ec_q <= XERR_NONE;
        end else begin
            st <= st_n;  hdr_q <= hdr_n; len_q <= len_n; cnt_q <= cnt_n;
            cv_q <= cv_n; cc_q <= cc_n; cb_q <= cb_n;
            rv_q <= rv_n; rd_q <= rd_n; dn_q <= dn_n; er_q <= er_n;
            ec_q <= ec_n;
        end
    end

    assign cmd_valid = cv_q;
    assign cmd_code  = cc_q;
    assign cmd_byte  = cb_q;
    assign rd_valid  = rv_q;
    assign rd_data   = rd_q;
    assign xfer_done = dn_q;
    assign xfer_err  = er_q;
    assign err_code  = ec_q;
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [6:0]       desc_addr,
    input  logic             desc_read,
    input  logic             desc_nostart,
    input  logic             desc_last,
    input  logic [LEN_W-1:0] desc_len,
    input  logic [TO_W-1:0]  timeout_limit,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             cmd_valid,
    output logic [3:0]       cmd_code,
    output logic [7:0]       cmd_byte,
    input  logic             cmd_done,
    input  logic [1:0]       cmd_status,
    input  logic [7:0]       cmd_rdata,
    output logic             xfer_done,
    output logic             xfer_err,
    output logic [1:0]       err_code
);
    msg_hdr_t  hdr;
    bus_cmd_e  code_e;
    xfer_err_e err_e;
    logic      accept, running, expired;

    assign hdr = '{addr: desc_addr, rd: desc_read, nostart: desc_nostart, last: desc_last};

    i2cseq_timer #(.TO_W(TO_W)) u_timer (
        .clk(clk), .rst(rst), .clear(accept), .run(running),
        .limit(timeout_limit), .expired(expired)
    );

    i2cseq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_hdr(hdr), .desc_len(desc_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_code(code_e), .cmd_byte(cmd_byte),
        .cmd_done(cmd_done), .cmd_status(cmd_status), .cmd_rdata(cmd_rdata),
        .tmo_expired(expired), .msg_accept(accept), .active(running),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .err_code(err_e)
    );

    assign cmd_code = code_e;
    assign err_code = err_e;
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       desc_valid,
    input logic       desc_ready,
    input logic       wr_ready,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic       cmd_done,
    input logic [1:0] cmd_status,
    input logic       rd_valid,
    input logic       xfer_done,
    input logic       xfer_err,
    input logic [1:0] err_code
);
    p_one_end_r7: assert property (@(posedge clk) disable iff (rst)
        !(xfer_done && xfer_err));

    p_done_after_stop_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> ($past(cmd_done) && $past(cmd_code) == 4'd10 && !$past(cmd_status[1])));

    p_abort_code_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && cmd_status[1] && !desc_ready && !wr_ready) |=> (xfer_err && err_code == 2'd1));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
        xfer_err |-> (desc_ready && !cmd_valid));

    p_read_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(cmd_done));

    p_start_on_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_code == 4'd1) |-> $past(desc_valid && desc_ready));

    p_cmd_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (!desc_ready && !wr_ready));
endmodule

bind i2cseq_top i2cseq_chk u_chk (.*);

// File: tb/test_i2cseq_top.sv
module test_i2cseq_top;
    localparam int LEN_W = 8;
    localparam int TO_W  = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic desc_valid = 0, desc_read = 0, desc_nostart = 0, desc_last = 0;
    logic [6:0] desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [TO_W-1:0] timeout_limit = 16'd2000;
    logic wr_valid = 0; logic [7:0] wr_data = '0;
    logic cmd_done = 0; logic [1:0] cmd_status = '0; logic [7:0] cmd_rdata = '0;
    logic desc_ready, wr_ready, rd_valid, cmd_valid, xfer_done, xfer_err;
    logic [7:0] rd_data, cmd_byte;
    logic [3:0] cmd_code;
    logic [1:0] err_code;

    always #5 clk = ~clk;

    i2cseq_top #(.LEN_W(LEN_W), .TO_W(TO_W)) i_i2cseq_top (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_read(desc_read), .desc_nostart(desc_nostart),
        .desc_last(desc_last), .desc_len(desc_len), .timeout_limit(timeout_limit),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_byte(cmd_byte), .cmd_done(cmd_done),
        .cmd_status(cmd_status), .cmd_rdata(cmd_rdata), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .err_code(err_code)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // message list and write data
    logic [6:0] m_addr[8]; logic m_rd[8]; logic m_ns[8]; int m_len[8]; int nmsg;
    logic [7:0] wbytes[64];
    int wptr; logic took;

    // byte engine model state
    logic mute = 0; int inj_idx = -1; int pend = 0; int ncmd = 0; int rcount = 0;
    logic [1:0] p_st; logic [7:0] p_rd;
    logic [3:0] log_code[64]; logic [7:0] log_byte[64];
    logic [7:0] rd_log[64]; int nrd = 0;
    logic seen_done = 0, seen_err = 0;

    // expectations
    logic [3:0] e_code[64]; logic [7:0] e_byte[64]; int e_n;
    int e_nrd; logic e_done; logic [1:0] e_ec;

    function automatic logic [7:0] rd_pattern(int k);
        return 8'(60 + 17 * k);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cmd_done = 1'b1; cmd_status = p_st; cmd_rdata = p_rd;
                end
            end
            if (cmd_valid && ncmd < 64) begin
                log_code[ncmd] = cmd_code;
                log_byte[ncmd] = cmd_byte;
                p_rd = 8'hxx;
                case (cmd_code)
                    4'd3: p_st = (ncmd == inj_idx) ? 2'd2 : 2'd1;
                    4'd6, 4'd7: begin
                        p_st = (ncmd == inj_idx) ? 2'd3 : 2'd0;
                        p_rd = rd_pattern(rcount); rcount++;
                    end
                    default: p_st = (ncmd == inj_idx) ? 2'd3 : 2'd0;
                endcase
                if (!mute) pend = 1 + int'($urandom % 3);
                ncmd++;
            end
            if (took) wptr++;
            wr_data  = wbytes[wptr % 64];
            wr_valid = (wptr < 64);
            took     = wr_valid && wr_ready;
            if (rd_valid && nrd < 64) begin rd_log[nrd] = rd_data; nrd++; end
            if (xfer_done) seen_done = 1'b1;
            if (xfer_err)  seen_err  = 1'b1;
        end
    end

    task automatic set_msg(int i, logic [6:0] a, logic r, logic ns, int len);
        m_addr[i] = a; m_rd[i] = r; m_ns[i] = ns; m_len[i] = len;
    endtask

    task automatic build_expected();
        int wi = 0; int ngets = 0;
        e_n = 0;
        for (int i = 0; i < nmsg; i++) begin
            if (!m_ns[i]) begin
                e_code[e_n] = (i == 0) ? 4'd1 : 4'd2; e_byte[e_n] = 8'h00; e_n++;
                e_code[e_n] = 4'd3; e_byte[e_n] = {m_addr[i], m_rd[i]}; e_n++;
            end
            for (int j = 0; j < m_len[i]; j++) begin
                if (m_rd[i]) begin
                    e_code[e_n] = (j == m_len[i] - 1) ? 4'd7 : 4'd6; e_byte[e_n] = 8'h00;
                end else begin
                    e_code[e_n] = 4'd3; e_byte[e_n] = wbytes[wi]; wi++;
                end
                e_n++;
            end
        end
        e_code[e_n] = 4'd10; e_byte[e_n] = 8'h00; e_n++;
        if (inj_idx >= 0 && inj_idx < e_n) begin
            e_n = inj_idx + 1; e_done = 1'b0; e_ec = 2'd1;
        end else begin
            e_done = 1'b1; e_ec = 2'd0;
        end
        for (int k = 0; k < e_n; k++)
            if ((e_code[k] == 4'd6 || e_code[k] == 4'd7) && k != inj_idx) ngets++;
        e_nrd = ngets;
    endtask

    task automatic run_xfer(string req, int inj);
        logic stop_feed = 1'b0;
        @(posedge clk);
        ncmd = 0; nrd = 0; rcount = 0; wptr = 0; took = 0; pend = 0;
        seen_done = 0; seen_err = 0; inj_idx = inj;
        for (int k = 0; k < 64; k++) wbytes[k] = 8'($urandom);
        build_expected();
        for (int i = 0; i < nmsg && !stop_feed; i++) begin
            @(negedge clk);
            desc_valid = 1'b1; desc_addr = m_addr[i]; desc_read = m_rd[i];
            desc_nostart = m_ns[i]; desc_last = (i == nmsg - 1);
            desc_len = LEN_W'(m_len[i]);
            forever begin
                if (xfer_err || xfer_done || seen_err || seen_done) begin
                    stop_feed = 1'b1; break;
                end
                if (desc_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
            desc_valid = 1'b0;
        end
        for (int t = 0; t < 3000 && !(seen_done || seen_err); t++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(req, "command count", ncmd, e_n);
        for (int k = 0; k < e_n && k < ncmd; k++) begin
            check(req, $sformatf("cmd %0d code", k), log_code[k], e_code[k]);
            if (e_code[k] == 4'd3)
                check(req, $sformatf("cmd %0d byte", k), log_byte[k], e_byte[k]);
        end
        check({req, " R5"}, "read count", nrd, e_nrd);
        for (int k = 0; k < e_nrd && k < nrd; k++)
            check("R5", $sformatf("read byte %0d", k), rd_log[k], rd_pattern(k));
        check("R7", "done seen", seen_done, e_done);
        check("R8", "error seen", seen_err, !e_done);
        check("R8", "err_code", err_code, e_ec);
        check("R8", "back to idle", desc_ready, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "desc_ready", desc_ready, 1'b1);
        check("R1", "cmd_valid", cmd_valid, 1'b0);
        check("R1", "done/err", {xfer_done, xfer_err}, 2'b00);
        check("R1", "err_code", err_code, 2'd0);

        // R3 R4 R6: write two, then repeated start and read three
        nmsg = 2; set_msg(0, 7'h50, 0, 0, 2); set_msg(1, 7'h50, 1, 0, 3);
        run_xfer("R3 R4 R6", -1);
        // R4: zero-length write goes straight to stop
        nmsg = 1; set_msg(0, 7'h21, 0, 0, 0);
        run_xfer("R4 zero-length", -1);
        // R2: no-start continuation of a write
        nmsg = 2; set_msg(0, 7'h11, 0, 0, 1); set_msg(1, 7'h11, 0, 1, 2);
        run_xfer("R2 continuation", -1);
        // R2: first message no-start read, no start or address at all
        nmsg = 1; set_msg(0, 7'h33, 1, 1, 2);
        run_xfer("R2 first nostart", -1);
        // R5: single byte read uses the no-ack request
        nmsg = 1; set_msg(0, 7'h7F, 1, 0, 1);
        run_xfer("R5 single read", -1);
        // R8: missing ack on the address byte
        nmsg = 2; set_msg(0, 7'h44, 0, 0, 3); set_msg(1, 7'h44, 1, 0, 2);
        run_xfer("R8 addr nack", 1);
        // R8: abort in the middle of a read
        nmsg = 1; set_msg(0, 7'h2A, 1, 0, 3);
        run_xfer("R8 read abort", 3);

        // R9: silent engine, exact timeout cycle
        begin
            int k = 0; logic early = 1'b0;
            mute = 1'b1; timeout_limit = 16'd20;
            @(posedge clk); ncmd = 0; inj_idx = -1; pend = 0;
            @(negedge clk);
            desc_valid = 1; desc_addr = 7'h12; desc_read = 0; desc_nostart = 0;
            desc_last = 1; desc_len = 8'd1;
            @(negedge clk); desc_valid = 0;
            while (!xfer_err && k < 100) begin
                @(negedge clk); k++;
                if (k == 20 && xfer_err) early = 1'b1;
            end
            check("R9", "timeout cycle", k, 21);
            check("R9", "no early abort", early, 1'b0);
            check("R9", "err_code", err_code, 2'd2);
            check("R9", "single command issued", ncmd, 1);
            @(negedge clk);
            check("R9", "idle after timeout", desc_ready, 1'b1);
            mute = 1'b0; timeout_limit = 16'd2000;
        end

        // R10 and general: random mixes with occasional injected errors
        for (int r = 0; r < 40; r++) begin
            int inj;
            nmsg = 1 + int'($urandom % 3);
            for (int i = 0; i < nmsg; i++)
                set_msg(i, 7'($urandom), 1'($urandom), (i > 0) ? 1'($urandom % 4 == 0) : 1'b0,
                        int'($urandom % 5));
            inj = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
            run_xfer("R10 random", inj);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule